// File: doc/BRIEF.md
# Motor-Control PWM Time Base

This block produces the timing for a three-phase motor drive. A 16-bit count, paced by a half-count phase bit, sweeps against a programmed period. Three duty values are compared with that count to form three complementary output pairs. Each pair has a high-side and a low-side output, and each output has its turn-on delayed by a programmable dead time. The block also provides a one-clock period interrupt pulse, a count-direction output, the running flag and the live count.

Software writes the run flag through a one-cycle write strobe. The counting style is chosen by a two-bit mode:

- **Sawtooth, repeating:** the count rises to the period and wraps to zero, again and again.
- **Sawtooth, single pass:** the count makes one sweep and then clears the run flag itself.
- **Triangle:** the count rises to the period and then falls back to zero, which gives center-aligned pulses.

The low bit of each duty value places the switching edge either at the start or in the middle of a count interval. This doubles the edge resolution.

Top module: `mcpwm_core`

## Requirements
- R1: After reset `tb_run` is 0, `tb_count` is 0 and every output is low. While `tb_run` is 0 the count holds at 0, `prd_irq` stays low, and `pwm_hi`/`pwm_lo` are all 0 from the next clock on.
- R2: A clock with `en_we`=1 loads `en_wdata` into `tb_run` at that edge. Clearing the flag brings `tb_count` to 0 and all six outputs low one clock later.
- R3: While running, the count advances at most once every two clocks. The first clock of each count value is phase 0 and the second is phase 1. Sample i after start (i=0 first) in sawtooth mode shows count i/2 (integer division).
- R4: With `tb_mode` 0 or 3 the count runs 0,1,…,P and then 0 again, so one period is 2(P+1) clocks. `prd_irq` is high for one clock, the second clock of count P. `cnt_down` stays 0.
- R5: With `tb_mode` 1 the count makes one 0…P pass. `tb_run` is high for exactly 2(P+1) clocks, during which exactly one `prd_irq` occurs. The run flag is then clear and the count rests at 0.
- R6: With `tb_mode` 2 the steady sequence is up 1…P and down P−1…0, so one period is 4P clocks. `cnt_down` is high for 2P of them. `prd_irq` pulses on the second clock of the down-going count 0, and the count then rises.
- R7: In sawtooth modes a channel's high side is wanted when {count, phase} < duty, taken as 17-bit values. This gives D active clocks per period for 0<D<2(P+1), and the low side is wanted for the rest. An odd duty therefore adds one clock, half a count.
- R8: In triangle mode the phase bit is inverted while counting down before the same comparison. For 2≤D≤2P the high side is wanted for 2D−2 clocks per period and the low side for the rest.
- R9: Each output follows its wanted level one clock later, except that its rising edge is delayed by a further `dead_cnt` clocks. A wanted run of L clocks yields a pulse of max(L−`dead_cnt`, 0) clocks, so a run no longer than the dead time is suppressed.
- R10: The high side and low side of a channel are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_we | input | 1 | Write strobe for the run flag |
| en_wdata | input | 1 | Value written to the run flag |
| tb_mode | input | 2 | 0/3 repeating sawtooth, 1 single pass, 2 triangle |
| period | input | CNT_W | Period value P |
| duty_vec | input | NCH*CNT_W | Duty values, channel g in bits [g*CNT_W +: CNT_W] |
| dead_cnt | input | DT_W | Turn-on delay in clocks |
| pwm_hi | output | NCH | High-side outputs, bit g = channel g |
| pwm_lo | output | NCH | Low-side outputs, bit g = channel g |
| prd_irq | output | 1 | One-clock period pulse |
| cnt_down | output | 1 | 1 while the count is falling |
| tb_run | output | 1 | Run flag |
| tb_count | output | CNT_W | Current count value |

## Verification
The sawtooth runs use period 9 with duties 7, 8 and 12 at zero dead time. The one-clock gap between 7 and 8 shows the half-count edge, and 12 shows the plain compare. The same period with a dead time of 3 and duties 7, 2 and 12 separates pulses that shrink from a pulse that vanishes, and the low sides show the complement losing the same delay. The triangle runs at period 6 use duties 4, 5 and 12, and then 5, 8 and 11 with a dead time of 1. These separate the center-aligned width rule and the inverted-phase half step from the sawtooth rule. Single-pass, stop-while-running and idle runs separate self-clearing from the write strobe.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;

    typedef enum logic [1:0] {
        MODE_SAW    = 2'd0,
        MODE_ONCE   = 2'd1,
        MODE_TRI    = 2'd2,
        MODE_SAW_B  = 2'd3
    } tb_mode_e;

    typedef struct packed {
        logic run;
        logic ph;
        logic dn;
    } tb_flags_t;

    // half-count bit: ascending uses phase, descending uses its inverse
    function automatic logic half_bit(input logic ph, input logic dn);
        return dn ? ~ph : ph;
    endfunction

endpackage

// File: rtl/mcpwm_timebase.sv
module mcpwm_timebase
    import mcpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_we,
    input  logic             en_wdata,
    input  tb_mode_e         mode,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt_o,
    output tb_flags_t        flags_o,
    output logic             irq_o
);

    logic [CNT_W-1:0] cnt_q;
    tb_flags_t        fl_q;
    logic             at_top;
    logic             at_zero;
    logic             step;

    assign at_top  = (cnt_q >= period);
    assign at_zero = (cnt_q == '0);
    assign step    = fl_q.run & fl_q.ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            fl_q  <= '0;
        end else if (!fl_q.run) begin
            cnt_q   <= '0;
            fl_q.ph <= 1'b0;
            fl_q.dn <= 1'b0;
            fl_q.run <= en_we & en_wdata;
        end else begin
            fl_q.ph <= ~fl_q.ph;
            if (en_we) fl_q.run <= en_wdata;
            if (fl_q.ph) begin
                if (mode == MODE_TRI) begin
                    if (!fl_q.dn) begin
                        if (at_top) begin
                            fl_q.dn <= 1'b1;
                            cnt_q   <= at_zero ? '0 : cnt_q - 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end else if (at_zero) begin
                        fl_q.dn <= 1'b0;
                        cnt_q   <= cnt_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end else begin
                    fl_q.dn <= 1'b0;
                    if (at_top) begin
                        cnt_q <= '0;
                        if (mode == MODE_ONCE && !en_we) fl_q.run <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end

    assign irq_o   = step & ((mode == MODE_TRI) ? (fl_q.dn & at_zero) : at_top);
    assign cnt_o   = cnt_q;
    assign flags_o = fl_q;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !fl_q.run |=> (cnt_q == '0)); // R1
    AST_HALF_STEP: assert property (@(posedge clk) disable iff (rst)
        (fl_q.run && !fl_q.ph) |=> $stable(cnt_q)); // R3
    AST_SAW_WRAP: assert property (@(posedge clk) disable iff (rst)
        (irq_o && mode != MODE_TRI) |=> (cnt_q == '0)); // R4
    AST_ONCE_STOP: assert property (@(posedge clk) disable iff (rst)
        (irq_o && mode == MODE_ONCE && !en_we) |=> !fl_q.run); // R5
    AST_TRI_TURN: assert property (@(posedge clk) disable iff (rst)
        (irq_o && mode == MODE_TRI) |=> !fl_q.dn); // R6

endmodule

// File: rtl/mcpwm_duty_cmp.sv
module mcpwm_duty_cmp
    import mcpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  tb_flags_t        flags,
    input  logic [CNT_W-1:0] duty,
    output logic             want_hi,
    output logic             want_lo
);

    logic [CNT_W:0] fine;
    logic           below;

    assign fine    = {cnt, half_bit(flags.ph, flags.dn)};
    assign below   = (fine < {1'b0, duty});
    assign want_hi = flags.run & below;
    assign want_lo = flags.run & ~below;

endmodule

// File: rtl/mcpwm_deadtime.sv
module mcpwm_deadtime #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            want,
    input  logic [DT_W-1:0] dead,
    output logic            drive
);

    logic [DT_W-1:0] age_q;
    logic            drv_q;

    always_ff @(posedge clk) begin
        if (rst || !want) begin
            age_q <= '0;
            drv_q <= 1'b0;
        end else if (age_q >= dead) begin
            drv_q <= 1'b1;
        end else begin
            age_q <= age_q + 1'b1;
        end
    end

    assign drive = drv_q;

    AST_DT_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        drv_q |-> $past(want)); // R9
    AST_DT_NODELAY: assert property (@(posedge clk) disable iff (rst)
        (dead == '0 && want) |=> drv_q); // R9

endmodule

// File: rtl/mcpwm_core.sv
module mcpwm_core
    import mcpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8,
    parameter int NCH   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_we,
    input  logic               en_wdata,
    input  logic [1:0]         tb_mode,
    input  logic [CNT_W-1:0]   period,
    input  logic [NCH*CNT_W-1:0] duty_vec,
    input  logic [DT_W-1:0]    dead_cnt,
    output logic [NCH-1:0]     pwm_hi,
    output logic [NCH-1:0]     pwm_lo,
    output logic               prd_irq,
    output logic               cnt_down,
    output logic               tb_run,
    output logic [CNT_W-1:0]   tb_count
);

    logic [CNT_W-1:0] cnt;
    tb_flags_t        fl;
    logic [NCH-1:0]   want_hi;
    logic [NCH-1:0]   want_lo;
    tb_mode_e         mode_e;

    assign mode_e = tb_mode_e'(tb_mode);

    mcpwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk      (clk),
        .rst      (rst),
        .en_we    (en_we),
        .en_wdata (en_wdata),
        .mode     (mode_e),
        .period   (period),
        .cnt_o    (cnt),
        .flags_o  (fl),
        .irq_o    (prd_irq)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        mcpwm_duty_cmp #(.CNT_W(CNT_W)) u_cmp (
            .cnt     (cnt),
            .flags   (fl),
            .duty    (duty_vec[g*CNT_W +: CNT_W]),
            .want_hi (want_hi[g]),
            .want_lo (want_lo[g])
        );

        mcpwm_deadtime #(.DT_W(DT_W)) u_dt_hi (
            .clk   (clk),
            .rst   (rst),
            .want  (want_hi[g]),
            .dead  (dead_cnt),
            .drive (pwm_hi[g])
        );

        mcpwm_deadtime #(.DT_W(DT_W)) u_dt_lo (
            .clk   (clk),
            .rst   (rst),
            .want  (want_lo[g]),
            .dead  (dead_cnt),
            .drive (pwm_lo[g])
        );

        AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (rst)
            !(pwm_hi[g] && pwm_lo[g])); // R10
    end

    assign cnt_down = fl.dn;
    assign tb_run   = fl.run;
    assign tb_count = cnt;

    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (rst)
        !fl.run |=> (pwm_hi == '0 && pwm_lo == '0)); // R1

endmodule

// File: tb/sim_mcpwm_core.sv
module sim_mcpwm_core;

    localparam int CW = 16;
    localparam int DW = 8;
    localparam int NC = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            en_we = 1'b0;
    logic            en_wdata = 1'b0;
    logic [1:0]      tb_mode = 2'd0;
    logic [CW-1:0]   period = '0;
    logic [NC*CW-1:0] duty_vec = '0;
    logic [DW-1:0]   dead_cnt = '0;
    logic [NC-1:0]   pwm_hi;
    logic [NC-1:0]   pwm_lo;
    logic            prd_irq;
    logic            cnt_down;
    logic            tb_run;
    logic [CW-1:0]   tb_count;

    always #5 clk = ~clk;

    mcpwm_core #(.CNT_W(CW), .DT_W(DW), .NCH(NC)) u0 (
        .clk(clk), .rst(rst), .en_we(en_we), .en_wdata(en_wdata),
        .tb_mode(tb_mode), .period(period), .duty_vec(duty_vec),
        .dead_cnt(dead_cnt), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .prd_irq(prd_irq), .cnt_down(cnt_down), .tb_run(tb_run),
        .tb_count(tb_count)
    );

    typedef struct {
        string req;
        string what;
        int    val;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    int m_win;
    int m_hi[NC];
    int m_lo[NC];
    int m_dn;
    int m_max;

    // driver side: queue an expected value
    task automatic expect_item(string req, string what, int val);
        exp_t e;
        e.req = req; e.what = what; e.val = val;
        exp_q.push_back(e);
    endtask

    // monitor side: pop and compare
    task automatic score(int act);
        exp_t e;
        n_tests++;
        if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard underflow (no requirement) actual=%0d expected=none", act);
            return;
        end
        e = exp_q.pop_front();
        if (act != e.val) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", e.req, e.what, act, e.val);
        end
    endtask

    task automatic check(string req, string what, int act, int expv);
        expect_item(req, what, expv);
        score(act);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_en(bit v);
        en_we = 1'b1;
        en_wdata = v;
        @(negedge clk);
        en_we = 1'b0;
    endtask

    task automatic configure(int md, int per, int d0, int d1, int d2, int dt);
        write_en(1'b0);
        tick(3);
        tb_mode  = md[1:0];
        period   = per[CW-1:0];
        duty_vec = {d2[CW-1:0], d1[CW-1:0], d0[CW-1:0]};
        dead_cnt = dt[DW-1:0];
        write_en(1'b1);
    endtask

    // monitor: accumulate one irq-to-irq window
    task automatic measure();
        int guard = 0;
        while (!prd_irq && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        m_win = 0; m_dn = 0; m_max = 0;
        for (int i = 0; i < NC; i++) begin
            m_hi[i] = 0; m_lo[i] = 0;
        end
        do begin
            m_win++;
            m_dn += int'(cnt_down);
            if (int'(tb_count) > m_max) m_max = int'(tb_count);
            for (int i = 0; i < NC; i++) begin
                m_hi[i] += int'(pwm_hi[i]);
                m_lo[i] += int'(pwm_lo[i]);
            end
            @(negedge clk);
            guard++;
        end while (!prd_irq && guard < 8000);
    endtask

    task automatic report_window();
        score(m_win);
        for (int i = 0; i < NC; i++) score(m_hi[i]);
        for (int i = 0; i < NC; i++) score(m_lo[i]);
        score(m_dn);
        score(m_max);
    endtask

    task automatic expect_window(string rw, string rh, string rd, int win,
                                 int h0, int h1, int h2, int l0, int l1, int l2,
                                 int dn, int mx);
        expect_item(rw, "window clocks", win);
        expect_item(rh, "hi ch0 clocks", h0);
        expect_item(rh, "hi ch1 clocks", h1);
        expect_item(rh, "hi ch2 clocks", h2);
        expect_item(rh, "lo ch0 clocks", l0);
        expect_item(rh, "lo ch1 clocks", l1);
        expect_item(rh, "lo ch2 clocks", l2);
        expect_item(rd, "down clocks", dn);
        expect_item(rw, "max count", mx);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired (all requirements) actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int irqs;
        int runs;

        // R1 reset state
        tick(3);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "run after reset", int'(tb_run), 0);
        check("R1", "count after reset", int'(tb_count), 0);
        check("R1", "hi after reset", int'(pwm_hi), 0);
        check("R1", "lo after reset", int'(pwm_lo), 0);
        irqs = 0;
        for (int k = 0; k < 20; k++) begin
            irqs += int'(prd_irq);
            if (tb_count != 0 || pwm_hi != 0 || pwm_lo != 0) irqs += 100;
            @(negedge clk);
        end
        check("R1", "idle irq/activity", irqs, 0);

        // R3 half-count pacing, R2 write strobe
        configure(0, 9, 7, 8, 12, 0);
        check("R2", "run set by write", int'(tb_run), 1);
        tick(5);
        check("R3", "count at sample 5", int'(tb_count), 2);
        tick(1);
        check("R3", "count at sample 6", int'(tb_count), 3);

        // R4 / R7 sawtooth, zero dead time (odd vs even duty)
        measure();
        expect_window("R4", "R7", "R4", 20, 7, 8, 12, 13, 12, 8, 0, 9);
        measure();
        report_window();

        // R9 sawtooth alias mode 3 with dead time 3, one pulse suppressed
        configure(3, 9, 7, 2, 12, 3);
        measure();
        expect_window("R4", "R9", "R4", 20, 4, 0, 9, 10, 15, 5, 0, 9);
        measure();
        report_window();

        // R6 / R8 triangle, zero dead time
        configure(2, 6, 4, 5, 12, 0);
        measure();
        check("R6", "count at irq", int'(tb_count), 0);
        check("R6", "down at irq", int'(cnt_down), 1);
        expect_window("R6", "R8", "R6", 24, 6, 8, 22, 18, 16, 2, 12, 6);
        measure();
        report_window();

        // R8 / R9 triangle with dead time 1
        configure(2, 6, 5, 8, 11, 1);
        measure();
        expect_window("R6", "R9", "R6", 24, 7, 13, 19, 15, 9, 3, 12, 6);
        measure();
        report_window();

        // R5 single pass
        configure(1, 5, 3, 4, 5, 0);
        runs = 0; irqs = 0;
        while (tb_run && runs < 1000) begin
            runs++;
            irqs += int'(prd_irq);
            @(negedge clk);
        end
        check("R5", "run clocks", runs, 12);
        check("R5", "irq count", irqs, 1);
        irqs = 0;
        for (int k = 0; k < 10; k++) begin
            irqs += int'(prd_irq) + int'(tb_run);
            @(negedge clk);
        end
        check("R5", "quiet after pass", irqs, 0);
        check("R5", "count rests", int'(tb_count), 0);

        // R2 stop while running
        configure(0, 9, 7, 8, 12, 0);
        tick(7);
        write_en(1'b0);
        check("R2", "run cleared", int'(tb_run), 0);
        tick(1);
        check("R2", "count cleared", int'(tb_count), 0);
        check("R2", "hi cleared", int'(pwm_hi), 0);
        check("R2", "lo cleared", int'(pwm_lo), 0);
        check("R10", "pair overlap", int'(|(pwm_hi & pwm_lo)), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule